// File: doc/BRIEF.md
# Single-Cycle Word Processor Core

This block is a 32-bit processor core in which every instruction finishes in one clock. It runs a small fixed-format subset: three register-to-register operations (add, subtract, set-on-signed-less-than), a word load, a word store and a branch on register equality. The core holds the program counter, a 32-entry register file, an opcode decoder, an ALU-control decoder, the ALU itself, and two small word memories, one for instructions and one for data.

The ALU-control decoder does not compare the whole function field. It uses three minimized two-level equations over the 2-bit ALU class from the opcode decoder and the four low function bits. As a result the block only gives defined results for the function codes listed below.

A host fills both memories through a load port while `run_i` is low. It then raises `run_i`, and the core fetches and retires one instruction per clock. Two observation read ports let the host read any register and any data-memory word without disturbing execution.

Top module: `sc_core`

## Requirements
- R1: While `rst_ni` is low, the program counter is 0. The first instruction fetched after reset is at byte address 0.
- R2: Opcode 0 with function code 32 writes rs + rt (modulo 2^32) into register rd. Fields: opcode [31:26], rs [25:21], rt [20:16], rd [15:11], function [5:0].
- R3: Opcode 0 with function code 34 writes rs − rt (modulo 2^32) into rd. This holds even when rd equals rs, in which case the old value of rs is used.
- R4: Opcode 0 with function code 42 writes 1 into rd when rs < rt as signed 32-bit numbers, and 0 otherwise.
- R5: Opcode 35 loads into register rt the data word at byte address rs + sign-extended immediate [15:0]. Address bits [7:2] select the word.
- R6: Opcode 43 stores register rt into the data word at rs + sign-extended immediate. No register changes.
- R7: For opcode 4, when rs equals rt the next PC is PC + 4 + (sign-extended immediate × 4). In every other case the next PC is PC + 4. An immediate of −2 lands 4 bytes before the branch itself.
- R8: Register 0 always reads as 0. Writes to it, from register ops or loads, have no effect.
- R9: While `run_i` is low, the PC, the registers and the data memory hold their values. In that state, `ld_we_i` writes `ld_data_i` into word `ld_addr_i` of instruction memory (`ld_sel_i` = 0) or data memory (`ld_sel_i` = 1).
- R10: An opcode other than 0, 4, 35 or 43 writes no register and no memory word, and advances the PC by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | High: execute one instruction per clock |
| ld_we_i | input | 1 | Load-port write strobe (used only while `run_i` is low) |
| ld_sel_i | input | 1 | Load target: 0 instruction memory, 1 data memory |
| ld_addr_i | input | 6 | Load-port word index |
| ld_data_i | input | 32 | Load-port data word |
| dbg_reg_i | input | 5 | Register index to observe |
| dbg_reg_o | output | 32 | Value of the observed register |
| dbg_mem_i | input | 6 | Data-memory word index to observe |
| dbg_mem_o | output | 32 | Value of the observed data word |
| pc_o | output | 32 | Current program counter |

## Verification
In one clock, a register can be the source of an instruction and that same instruction's write target. A branch can also compare a register that the previous clock's load or ALU operation just wrote. The bench provokes both with a directed program that includes `sub r9,r9,r1` and a taken branch right after a load. It also runs random programs whose register indices are drawn from a narrow pool of 16, so that reuse is frequent. A bench-side instruction model predicts the PC after every edge and the full register and memory state at the end of each program. The RTL is judged against that model.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int unsigned REG_AW = 5;
  localparam int unsigned INSN_W = 32;

  localparam logic [5:0] OPC_RTYPE = 6'd0;
  localparam logic [5:0] OPC_BEQ   = 6'd4;
  localparam logic [5:0] OPC_LW    = 6'd35;
  localparam logic [5:0] OPC_SW    = 6'd43;

  // ALU class from the opcode decoder
  localparam logic [1:0] CLS_ADD   = 2'b00;
  localparam logic [1:0] CLS_SUB   = 2'b01;
  localparam logic [1:0] CLS_FUNCT = 2'b10;

  // ALU operation {negate_b, sel[1:0]}
  localparam logic [2:0] ALU_ADD = 3'b010;
  localparam logic [2:0] ALU_SUB = 3'b110;
  localparam logic [2:0] ALU_SLT = 3'b111;

  typedef struct packed {
    logic       dst_is_rd;
    logic       b_is_imm;
    logic       wb_from_mem;
    logic       rf_we;
    logic       mem_re;
    logic       mem_we;
    logic       is_branch;
    logic [1:0] alu_cls;
  } ctrl_t;
endpackage

// File: rtl/sc_decode.sv
module sc_decode
  import sc_pkg::*;
(
  input  logic [5:0] opcode_i,
  input  logic [3:0] funct_i,
  output ctrl_t      ctrl_o,
  output logic [2:0] alu_op_o
);
  logic negate_b, sel1, sel0;

  always_comb begin
    ctrl_o = '0;
    case (opcode_i)
      OPC_RTYPE: begin
        ctrl_o.dst_is_rd = 1'b1;
        ctrl_o.rf_we     = 1'b1;
        ctrl_o.alu_cls   = CLS_FUNCT;
      end
      OPC_LW: begin
        ctrl_o.b_is_imm    = 1'b1;
        ctrl_o.wb_from_mem = 1'b1;
        ctrl_o.rf_we       = 1'b1;
        ctrl_o.mem_re      = 1'b1;
        ctrl_o.alu_cls     = CLS_ADD;
      end
      OPC_SW: begin
        ctrl_o.b_is_imm = 1'b1;
        ctrl_o.mem_we   = 1'b1;
        ctrl_o.alu_cls  = CLS_ADD;
      end
      OPC_BEQ: begin
        ctrl_o.is_branch = 1'b1;
        ctrl_o.alu_cls   = CLS_SUB;
      end
      default: ctrl_o = '0;
    endcase
  end

  // two-level ALU control over class and low function bits
  assign negate_b = ctrl_o.alu_cls[0] | (ctrl_o.alu_cls[1] & funct_i[1]);
  assign sel0     = ctrl_o.alu_cls[1] & (funct_i[0] | funct_i[3]);
  assign sel1     = ~ctrl_o.alu_cls[1] | ~funct_i[2];
  assign alu_op_o = {negate_b, sel1, sel0};

  always_comb begin
    if (ctrl_o.mem_we) begin
      a_r6_store_no_wb: assert (!ctrl_o.rf_we)
        else $error("store requests a register write");
    end
    if (!(opcode_i inside {OPC_RTYPE, OPC_LW, OPC_SW, OPC_BEQ})) begin
      a_r10_unknown_quiet: assert (!ctrl_o.rf_we && !ctrl_o.mem_we && !ctrl_o.is_branch)
        else $error("unknown opcode has side effects");
    end
    if (opcode_i == OPC_LW || opcode_i == OPC_SW) begin
      a_r5_addr_adds: assert (alu_op_o == ALU_ADD)
        else $error("memory address not computed by add");
    end
  end
endmodule

// File: rtl/sc_alu.sv
module sc_alu #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [2:0]   op_i,
  output logic [W-1:0] res_o,
  output logic         zero_o
);
  logic [W-1:0] b_eff, sum;
  logic         ovf, less;

  assign b_eff = op_i[2] ? ~b_i : b_i;
  assign sum   = a_i + b_eff + {{(W-1){1'b0}}, op_i[2]};
  assign ovf   = (a_i[W-1] == b_eff[W-1]) && (sum[W-1] != a_i[W-1]);
  assign less  = sum[W-1] ^ ovf;

  always_comb begin
    case (op_i[1:0])
      2'b00:   res_o = a_i & b_eff;
      2'b01:   res_o = a_i | b_eff;
      2'b10:   res_o = sum;
      default: res_o = {{(W-1){1'b0}}, less};
    endcase
  end

  assign zero_o = (res_o == '0);

  always_comb begin
    if (op_i == 3'b110) begin
      a_r7_zero_on_equal: assert (zero_o == (a_i == b_i))
        else $error("zero flag disagrees with equality");
    end
    if (op_i == 3'b111) begin
      a_r4_slt_signed: assert (res_o[0] == ($signed(a_i) < $signed(b_i)))
        else $error("slt result wrong");
    end
  end
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int unsigned AW  = 5,
  parameter int unsigned W   = 32,
  parameter int unsigned NRD = 3,
  localparam int unsigned N  = 1 << AW
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    we_i,
  input  logic [AW-1:0]           waddr_i,
  input  logic [W-1:0]            wdata_i,
  input  logic [NRD-1:0][AW-1:0]  raddr_i,
  output logic [NRD-1:0][W-1:0]   rdata_o
);
  logic [W-1:0] regs_q [N];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N; i++) regs_q[i] <= '0;
    end else if (we_i && waddr_i != '0) begin
      regs_q[waddr_i] <= wdata_i;
    end
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rdata_o[g] = (raddr_i[g] == '0) ? '0 : regs_q[raddr_i[g]];
  end

  a_r8_r0_stays_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    regs_q[0] == '0);
  a_r8_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && waddr_i != '0) |=> regs_q[$past(waddr_i)] == $past(wdata_i));
endmodule

// File: rtl/sc_mem.sv
module sc_mem #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned W     = 32,
  parameter int unsigned NRD   = 1,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic                   clk_i,
  input  logic                   we_i,
  input  logic [AW-1:0]          waddr_i,
  input  logic [W-1:0]           wdata_i,
  input  logic [NRD-1:0][AW-1:0] raddr_i,
  output logic [NRD-1:0][W-1:0]  rdata_o
);
  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rdata_o[g] = mem_q[raddr_i[g]];
  end
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int unsigned XLEN     = 32,
  parameter int unsigned IM_DEPTH = 64,
  parameter int unsigned DM_DEPTH = 64,
  localparam int unsigned IM_AW   = $clog2(IM_DEPTH),
  localparam int unsigned DM_AW   = $clog2(DM_DEPTH),
  localparam int unsigned LD_AW   = (IM_AW > DM_AW) ? IM_AW : DM_AW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              ld_we_i,
  input  logic              ld_sel_i,
  input  logic [LD_AW-1:0]  ld_addr_i,
  input  logic [XLEN-1:0]   ld_data_i,
  input  logic [REG_AW-1:0] dbg_reg_i,
  output logic [XLEN-1:0]   dbg_reg_o,
  input  logic [DM_AW-1:0]  dbg_mem_i,
  output logic [XLEN-1:0]   dbg_mem_o,
  output logic [XLEN-1:0]   pc_o
);
  logic [XLEN-1:0]   pc_q, pc_plus4, br_target, pc_next;
  logic [INSN_W-1:0] insn;
  logic [5:0]        opcode;
  logic [REG_AW-1:0] rs, rt, rd, rf_waddr;
  logic [XLEN-1:0]   imm_sext, rs_val, rt_val, alu_b, alu_res, dm_rdata, rf_wdata;
  logic [2:0]        alu_op;
  logic              alu_zero, take_br;
  ctrl_t             ctrl;

  logic                      im_we, dm_we;
  logic [DM_AW-1:0]          dm_waddr;
  logic [XLEN-1:0]           dm_wdata;
  logic [1:0][DM_AW-1:0]     dm_raddr;
  logic [1:0][XLEN-1:0]      dm_rdata_all;
  logic [2:0][REG_AW-1:0]    rf_raddr;
  logic [2:0][XLEN-1:0]      rf_rdata;
  logic                      unused_bits;

  // fetch
  sc_mem #(.DEPTH(IM_DEPTH), .W(INSN_W), .NRD(1)) i_imem (
    .clk_i   (clk_i),
    .we_i    (im_we),
    .waddr_i (ld_addr_i[IM_AW-1:0]),
    .wdata_i (ld_data_i[INSN_W-1:0]),
    .raddr_i (pc_q[IM_AW+1:2]),
    .rdata_o (insn)
  );

  assign opcode   = insn[31:26];
  assign rs       = insn[25:21];
  assign rt       = insn[20:16];
  assign rd       = insn[15:11];
  assign imm_sext = {{(XLEN-16){insn[15]}}, insn[15:0]};

  sc_decode i_decode (
    .opcode_i (opcode),
    .funct_i  (insn[3:0]),
    .ctrl_o   (ctrl),
    .alu_op_o (alu_op)
  );

  // register file: port 0 rs, port 1 rt, port 2 observation
  assign rf_raddr = {dbg_reg_i, rt, rs};
  assign rf_waddr = ctrl.dst_is_rd ? rd : rt;
  assign rf_wdata = ctrl.wb_from_mem ? dm_rdata : alu_res;

  sc_regfile #(.AW(REG_AW), .W(XLEN), .NRD(3)) i_regfile (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (run_i & ctrl.rf_we),
    .waddr_i (rf_waddr),
    .wdata_i (rf_wdata),
    .raddr_i (rf_raddr),
    .rdata_o (rf_rdata)
  );

  assign rs_val    = rf_rdata[0];
  assign rt_val    = rf_rdata[1];
  assign dbg_reg_o = rf_rdata[2];

  assign alu_b = ctrl.b_is_imm ? imm_sext : rt_val;

  sc_alu #(.W(XLEN)) i_alu (
    .a_i    (rs_val),
    .b_i    (alu_b),
    .op_i   (alu_op),
    .res_o  (alu_res),
    .zero_o (alu_zero)
  );

  // data memory: port 0 core, port 1 observation; load port owns writes while halted
  assign im_we    = ~run_i & ld_we_i & ~ld_sel_i;
  assign dm_we    = run_i ? ctrl.mem_we : (ld_we_i & ld_sel_i);
  assign dm_waddr = run_i ? alu_res[DM_AW+1:2] : ld_addr_i[DM_AW-1:0];
  assign dm_wdata = run_i ? rt_val : ld_data_i;
  assign dm_raddr = {dbg_mem_i, alu_res[DM_AW+1:2]};

  sc_mem #(.DEPTH(DM_DEPTH), .W(XLEN), .NRD(2)) i_dmem (
    .clk_i   (clk_i),
    .we_i    (dm_we),
    .waddr_i (dm_waddr),
    .wdata_i (dm_wdata),
    .raddr_i (dm_raddr),
    .rdata_o (dm_rdata_all)
  );

  assign dm_rdata  = dm_rdata_all[0];
  assign dbg_mem_o = dm_rdata_all[1];

  // next PC
  assign pc_plus4  = pc_q + XLEN'(4);
  assign br_target = pc_plus4 + {imm_sext[XLEN-3:0], 2'b00};
  assign take_br   = ctrl.is_branch & alu_zero;
  assign pc_next   = take_br ? br_target : pc_plus4;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pc_q <= '0;
    else if (run_i) pc_q <= pc_next;
  end

  assign pc_o = pc_q;

  assign unused_bits = ^{insn[10:4], ctrl.mem_re};

  a_r9_pc_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> pc_q == $past(pc_q));
  a_r7_pc_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !take_br) |=> pc_q == $past(pc_q) + XLEN'(4));
  a_r7_pc_branch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && take_br) |=> pc_q == $past(pc_q) + XLEN'(4) + ($past(imm_sext) << 2));
  a_r9_no_store_halted: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !ld_we_i) |-> !dm_we);
endmodule

// File: tb/test_sc_core.sv
module test_sc_core;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        run_i = 1'b0;
  logic        ld_we_i = 1'b0;
  logic        ld_sel_i = 1'b0;
  logic [5:0]  ld_addr_i = '0;
  logic [31:0] ld_data_i = '0;
  logic [4:0]  dbg_reg_i = '0;
  logic [31:0] dbg_reg_o;
  logic [5:0]  dbg_mem_i = '0;
  logic [31:0] dbg_mem_o;
  logic [31:0] pc_o;

  always #5 clk_i = ~clk_i;

  sc_core i_sc_core (.*);

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  logic [31:0] m_reg  [32];
  logic [31:0] m_dmem [64];
  logic [31:0] m_imem [64];
  logic [31:0] m_pc;

  localparam logic [31:0] HALT = {6'd4, 5'd0, 5'd0, 16'hFFFF};

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, int fn);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, 6'(fn)};
  endfunction

  function automatic logic [31:0] enc_i(int op, int rs, int rt, logic [15:0] imm);
    return {6'(op), 5'(rs), 5'(rt), imm};
  endfunction

  // independent instruction model
  task automatic model_step();
    logic [31:0] ins, a, b, sx, addr, res, npc;
    ins  = m_imem[m_pc[7:2]];
    a    = m_reg[ins[25:21]];
    b    = m_reg[ins[20:16]];
    sx   = {{16{ins[15]}}, ins[15:0]};
    addr = a + sx;
    npc  = m_pc + 32'd4;
    res  = '0;
    case (ins[31:26])
      6'd0: begin
        case (ins[5:0])
          6'd32: res = a + b;
          6'd34: res = a - b;
          6'd42: res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
          default: res = '0;
        endcase
        if (ins[15:11] != 5'd0) m_reg[ins[15:11]] = res;
      end
      6'd35: if (ins[20:16] != 5'd0) m_reg[ins[20:16]] = m_dmem[addr[7:2]];
      6'd43: m_dmem[addr[7:2]] = b;
      6'd4:  if (a == b) npc = m_pc + 32'd4 + (sx << 2);
      default: ;
    endcase
    m_pc = npc;
  endtask

  task automatic load_word(bit sel, int idx, logic [31:0] data);
    @(negedge clk_i);
    ld_we_i = 1'b1; ld_sel_i = sel; ld_addr_i = 6'(idx); ld_data_i = data;
    @(posedge clk_i);
    #1 ld_we_i = 1'b0;
    if (sel) m_dmem[idx] = data; else m_imem[idx] = data;
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    run_i = 1'b0; rst_ni = 1'b0;
    @(negedge clk_i);
    chk("R1", "pc in reset", pc_o, 32'd0);
    rst_ni = 1'b1;
    for (int r = 0; r < 32; r++) m_reg[r] = '0;
    m_pc = '0;
    @(negedge clk_i);
    chk("R1", "pc after reset", pc_o, 32'd0);
  endtask

  task automatic run_cycles(int n);
    @(negedge clk_i);
    run_i = 1'b1;
    for (int c = 0; c < n; c++) begin
      @(posedge clk_i);
      model_step();
      @(negedge clk_i);
      chk("R7", "pc per cycle", pc_o, m_pc);
    end
    run_i = 1'b0;
  endtask

  task automatic peek_reg(int r, output logic [31:0] v);
    dbg_reg_i = 5'(r); #1 v = dbg_reg_o;
  endtask

  task automatic peek_mem(int w, output logic [31:0] v);
    dbg_mem_i = 6'(w); #1 v = dbg_mem_o;
  endtask

  task automatic check_all(string req);
    logic [31:0] v;
    for (int r = 0; r < 32; r++) begin
      peek_reg(r, v);
      chk(req, $sformatf("reg %0d", r), v, m_reg[r]);
    end
    for (int w = 0; w < 64; w++) begin
      peek_mem(w, v);
      chk(req, $sformatf("mem %0d", w), v, m_dmem[w]);
    end
  endtask

  function automatic logic [31:0] rand_insn();
    int k, f;
    k = $urandom_range(0, 9);
    f = $urandom_range(0, 2);
    if (k <= 5)
      return enc_r($urandom_range(0, 15), $urandom_range(0, 15), $urandom_range(0, 15),
                   (f == 0) ? 32 : (f == 1) ? 34 : 42);
    else if (k <= 7)
      return enc_i(35, 0, $urandom_range(0, 15), 16'($urandom_range(0, 63) * 4));
    else if (k == 8)
      return enc_i(43, 0, $urandom_range(0, 15), 16'($urandom_range(0, 63) * 4));
    else
      return enc_i(4, $urandom_range(0, 3), $urandom_range(0, 3), 16'($urandom_range(0, 3)));
  endfunction

  initial begin
    logic [31:0] prog [17];
    logic [31:0] v;
    void'($urandom(32'd4242));

    do_reset();

    // directed program
    prog[0]  = enc_i(35, 0, 5, 16'd0);
    prog[1]  = enc_i(35, 0, 1, 16'd4);
    prog[2]  = enc_r(5, 1, 9, 32);
    prog[3]  = enc_r(9, 5, 6, 34);
    prog[4]  = enc_r(6, 9, 2, 42);
    prog[5]  = enc_i(35, 0, 3, 16'd8);
    prog[6]  = enc_r(3, 0, 4, 42);
    prog[7]  = enc_r(9, 3, 7, 42);
    prog[8]  = enc_r(9, 9, 0, 32);
    prog[9]  = enc_i(43, 0, 9, 16'd12);
    prog[10] = enc_i(4, 6, 1, 16'd1);
    prog[11] = enc_r(9, 9, 8, 32);
    prog[12] = enc_i(4, 9, 5, 16'd5);
    prog[13] = enc_r(9, 1, 9, 34);
    prog[14] = enc_i(8, 9, 10, 16'd5);
    prog[15] = enc_i(35, 0, 0, 16'd0);
    prog[16] = enc_i(4, 0, 0, 16'hFFFE);
    for (int i = 0; i < 64; i++) load_word(1'b0, i, (i < 17) ? prog[i] : HALT);
    for (int i = 0; i < 64; i++) load_word(1'b1, i, 32'h1000_0000 + 32'(i));
    load_word(1'b1, 0, 32'd7);
    load_word(1'b1, 1, 32'd5);
    load_word(1'b1, 2, 32'hFFFF_FFFD);
    load_word(1'b1, 3, 32'h0000_DEAD);

    peek_mem(2, v); chk("R9", "dmem load port", v, 32'hFFFF_FFFD);
    chk("R9", "pc held while loading", pc_o, 32'd0);

    run_cycles(16);
    chk("R7", "pc after directed run (-2 loop)", pc_o, 32'd60);
    peek_reg(5, v);  chk("R5", "lw r5", v, 32'd7);
    peek_reg(3, v);  chk("R5", "lw r3 negative", v, 32'hFFFF_FFFD);
    peek_reg(6, v);  chk("R3", "sub r6", v, 32'd5);
    peek_reg(9, v);  chk("R3", "sub r9 self source", v, 32'd7);
    peek_reg(2, v);  chk("R4", "slt positive", v, 32'd1);
    peek_reg(4, v);  chk("R4", "slt negative vs zero", v, 32'd1);
    peek_reg(7, v);  chk("R4", "slt false", v, 32'd0);
    peek_reg(0, v);  chk("R8", "r0 after add and lw", v, 32'd0);
    peek_reg(8, v);  chk("R7", "skipped by taken beq", v, 32'd0);
    peek_reg(10, v); chk("R10", "unknown opcode no write", v, 32'd0);
    peek_mem(3, v);  chk("R6", "sw wrote add result", v, 32'd12);
    peek_mem(4, v);  chk("R6", "neighbour word intact", v, 32'h1000_0004);
    peek_reg(1, v);  chk("R2", "lw r1 used by add", v, 32'd5);

    repeat (4) @(negedge clk_i);
    chk("R9", "pc held with run low", pc_o, 32'd60);
    peek_reg(9, v); chk("R9", "reg held with run low", v, 32'd7);

    // random programs against the model
    for (int round = 0; round < 4; round++) begin
      do_reset();
      for (int i = 0; i < 64; i++) load_word(1'b1, i, $urandom());
      for (int i = 0; i < 64; i++) begin
        if (i < 8)       load_word(1'b0, i, enc_i(35, 0, i + 1, 16'(i * 4)));
        else if (i < 56) load_word(1'b0, i, rand_insn());
        else             load_word(1'b0, i, HALT);
      end
      run_cycles(70);
      check_all("R2 R3 R4 R5 R6 R8");
    end

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL R7 watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule